// File: doc/BRIEF.md
# Address-Line Isolation Tester

This engine probes the address wiring of a byte-wide memory one address line at a time. It is aimed at stuck, bridged or aliased address bits and at chip-select decoding faults. After a start pulse it writes a byte to a base address and then to one address per address line in the selected group. Each of those addresses differs from the base in exactly that one line. Every point receives its own signature byte. When the last write has been accepted the engine idles for a programmable number of cycles. It then reads the points back in the same order and compares each byte with the signature it wrote.

The memory is reached through a request stream (valid/ready) and a read-response stream (valid/ready). A request is held unchanged while `req_valid` is high and `req_ready` is low. Only one read is ever outstanding, and `rsp_ready` is high only while that read waits for its data. The mode, scope and delay inputs are sampled on the accepted start. Software-free status pins report progress, pass or fail, and on a failure they hold the first failing address together with the expected and returned bytes.

Top module: `addr_line_tester`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `req_valid` and `rsp_ready` are all low.
- R2: A `start` seen while `busy` is low begins a run, and `busy` is high on the next cycle. A `start` seen while `busy` is high has no effect on the run's request sequence or outcome.
- R3: With `invert` low, point 0 is address 0. Point k (k ≥ 1) is the address with only bit (F + k - 1) set, where F = 0 when `upper_scope` is low (lines 0..7, giving 9 points) and F = 8 when it is high (lines 8..ADDR_W-1). Points are visited in ascending k.
- R4: With `invert` high, point 0 is all ones, and point k is all ones with bit (F + k - 1) cleared. F and the ordering are the same as in R3.
- R5: The byte written to point k, and expected back from it, is ((k × 0x1D) mod 256) XOR 0xA5.
- R6: Every point is written before any point is read. Reads follow the same point order, with exactly one read outstanding at a time.
- R7: After the handshake of the last write, `req_valid` stays low for exactly `delay_cycles` + 1 cycles before the first read request.
- R8: While `req_valid` is high and `req_ready` is low, the request fields hold steady. `rsp_ready` is high exactly from the cycle after a read handshake up to and including the response handshake.
- R9: If every byte matches, the run ends with `done` high, `fail` low and `busy` low on the cycle after the last response handshake. These levels hold until the next start.
- R10: At the first mismatch the run stops and issues no further requests. `done` and `fail` go high, and `fail_addr`, `fail_exp` and `fail_got` hold that point's address, its signature and the returned byte.
- R11: An accepted start clears `done` and `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle or finished |
| invert | input | 1 | 1: one-cold points on an all-ones base |
| upper_scope | input | 1 | 1: test lines 8..ADDR_W-1, 0: lines 0..7 |
| delay_cycles | input | DLY_W | Idle gap between write and read phases |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | Finished run found a mismatch |
| fail_addr | output | ADDR_W | Address of first mismatch |
| fail_exp | output | 8 | Signature expected there |
| fail_got | output | 8 | Byte actually returned |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_write | output | 1 | 1 write, 0 read |
| req_addr | output | ADDR_W | Request address |
| req_wdata | output | 8 | Write byte |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Engine waits for read data |
| rsp_data | input | 8 | Read data |

## Verification
The bench models a memory whose address can have bits forced to 0 or 1. An engine that did not give each point a distinct byte, or that read a point right after writing it, would pass these aliased memories. The bench expects the first failing point and the overwriting signature. It randomly stalls `req_ready` and delays responses. An engine that changed its request under back-pressure, or that ran the delay one cycle short or long, is caught by the per-cycle comparison of request order and of the write-to-read gap. A stray start is injected mid-run, and an engine that restarted would break the expected request order. Runs that follow a failing run catch an engine that kept the old `fail` flag.

// File: rtl/alt_pkg.sv
package alt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_DLY,
    ST_RD,
    ST_RSP,
    ST_DONE
  } alt_state_e;

  // signature byte for point index k
  function automatic logic [7:0] sig_of(input logic [7:0] k);
    logic [7:0] prod;
    prod = k * 8'h1D;
    return prod ^ 8'hA5;
  endfunction

endpackage

// File: rtl/alt_point_gen.sv
module alt_point_gen
  import alt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              invert,
  input  logic              upper,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        sig,
  output logic [IDX_W-1:0]  last_idx
);
  localparam int HIGH_LINES = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] flip;
  int first_line;

  assign first_line = upper ? PAGE_W : 0;

  always_comb begin
    flip = '0;
    for (int b = 0; b < ADDR_W; b++) begin
      if ((idx != '0) && ((int'(idx) + first_line - 1) == b)) flip[b] = 1'b1;
    end
  end

  assign addr     = {ADDR_W{invert}} ^ flip;
  assign sig      = sig_of(8'(idx));
  assign last_idx = upper ? IDX_W'(HIGH_LINES) : IDX_W'(PAGE_W);

endmodule

// File: rtl/alt_delay.sv
module alt_delay #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= value;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/addr_line_tester.sv
module addr_line_tester
  import alt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int DLY_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              invert,
  input  logic              upper_scope,
  input  logic [DLY_W-1:0]  delay_cycles,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [7:0]        fail_exp,
  output logic [7:0]        fail_got,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_wdata,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [7:0]        rsp_data
);
  localparam int HIGH_LINES = ADDR_W - PAGE_W;
  localparam int MAX_LINES  = (PAGE_W > HIGH_LINES) ? PAGE_W : HIGH_LINES;
  localparam int IDX_W      = $clog2(MAX_LINES + 1) + 1;

  alt_state_e        st;
  logic [IDX_W-1:0]  idx, last_idx;
  logic              inv_q, up_q;
  logic [DLY_W-1:0]  dly_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [7:0]        cur_sig;
  logic              tmr_load, tmr_done;
  logic              wr_hs, rd_hs, rsp_hs, start_ok, at_last;

  alt_point_gen #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_gen (
    .idx(idx), .invert(inv_q), .upper(up_q),
    .addr(cur_addr), .sig(cur_sig), .last_idx(last_idx)
  );

  alt_delay #(.W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .value(dly_q), .expired(tmr_done)
  );

  assign at_last  = (idx == last_idx);
  assign wr_hs    = (st == ST_WR)  && req_ready;
  assign rd_hs    = (st == ST_RD)  && req_ready;
  assign rsp_hs   = (st == ST_RSP) && rsp_valid;
  assign start_ok = start && ((st == ST_IDLE) || (st == ST_DONE));
  assign tmr_load = wr_hs && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      idx       <= '0;
      inv_q     <= 1'b0;
      up_q      <= 1'b0;
      dly_q     <= '0;
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_got  <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_DONE: begin
          if (start_ok) begin
            st    <= ST_WR;
            idx   <= '0;
            inv_q <= invert;
            up_q  <= upper_scope;
            dly_q <= delay_cycles;
            fail  <= 1'b0;
          end
        end
        ST_WR: begin
          if (wr_hs) begin
            if (at_last) begin
              st  <= ST_DLY;
              idx <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_DLY: begin
          if (tmr_done) st <= ST_RD;
        end
        ST_RD: begin
          if (rd_hs) st <= ST_RSP;
        end
        ST_RSP: begin
          if (rsp_hs) begin
            if (rsp_data != cur_sig) begin
              st        <= ST_DONE;
              fail      <= 1'b1;
              fail_addr <= cur_addr;
              fail_exp  <= cur_sig;
              fail_got  <= rsp_data;
            end else if (at_last) begin
              st <= ST_DONE;
            end else begin
              idx <= idx + 1'b1;
              st  <= ST_RD;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st == ST_WR) || (st == ST_DLY) || (st == ST_RD) || (st == ST_RSP);
  assign done      = (st == ST_DONE);
  assign req_valid = (st == ST_WR) || (st == ST_RD);
  assign req_write = (st == ST_WR);
  assign req_addr  = cur_addr;
  assign req_wdata = cur_sig;
  assign rsp_ready = (st == ST_RSP);

  // R8: request fields steady under back-pressure
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_write) && $stable(req_wdata)));

  // R2: idle start launches a run
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R9: finished and running are exclusive
  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R10: a failure is reported only on a finished run, with differing bytes
  assert_fail_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (done && (fail_exp != fail_got)));

  // R6: no new request while a read is outstanding
  assert_one_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  // R8: a read handshake opens the response window
  assert_rsp_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_ready);

endmodule

// File: tb/addr_line_tester_test.sv
module addr_line_tester_test;
  localparam int ADDR_W = 16;
  localparam int DLY_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              invert = 1'b0;
  logic              upper_scope = 1'b0;
  logic [DLY_W-1:0]  delay_cycles = '0;
  logic              busy, done, fail;
  logic [ADDR_W-1:0] fail_addr;
  logic [7:0]        fail_exp, fail_got;
  logic              req_valid, req_write, rsp_ready;
  logic              req_ready = 1'b0;
  logic [ADDR_W-1:0] req_addr;
  logic [7:0]        req_wdata;
  logic              rsp_valid = 1'b0;
  logic [7:0]        rsp_data = 8'h00;

  always #4 clk = ~clk;

  addr_line_tester #(.ADDR_W(ADDR_W), .PAGE_W(8), .DLY_W(DLY_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .invert(invert),
    .upper_scope(upper_scope), .delay_cycles(delay_cycles),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_got(fail_got),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // faulty memory model
  logic [7:0] mem [int];
  int stuck0 = 0;
  int stuck1 = 0;

  function automatic int phys(input int a);
    return ((a & ~stuck0) | stuck1) & 32'hFFFF;
  endfunction

  function automatic int sigb(input int k);
    return ((k * 29) ^ 165) & 255;
  endfunction

  bit cur_inv = 0;
  bit cur_up  = 0;
  int cur_dly = 0;

  function automatic int nlines();
    return cur_up ? (ADDR_W - 8) : 8;
  endfunction

  function automatic int pt_addr(input int k);
    int base;
    base = cur_inv ? 32'hFFFF : 0;
    if (k == 0) return base;
    return (base ^ (1 << ((cur_up ? 8 : 0) + k - 1))) & 32'hFFFF;
  endfunction

  // behavioural reference model state
  bit m_busy = 0, m_done = 0, m_fail = 0;
  int mf_addr = 0, mf_e = 0, mf_g = 0;
  int wr_k = 0, rd_k = 0, gap = 0, lat = 0, rsp_a = 0;
  bit gap_on = 0, rsp_pend = 0, consumed = 0, outst = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      req_ready <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      chk(busy == m_busy, "R2", "busy per cycle", busy, m_busy);
      chk(done == m_done, "R9", "done per cycle", done, m_done);
      chk(rsp_ready == outst, "R8", "rsp_ready window", rsp_ready, outst);
      if (!m_busy) chk(req_valid == 1'b0, "R10", "no request when not running", req_valid, 0);

      if (gap_on) begin
        if (req_valid) begin
          chk(gap == cur_dly + 1, "R7", "write-to-read gap", gap, cur_dly + 1);
          gap_on = 0;
        end else gap++;
      end

      if (consumed) begin
        rsp_valid = 1'b0;
        consumed  = 0;
      end else if (rsp_pend) begin
        if (lat == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = mem.exists(phys(rsp_a)) ? mem[phys(rsp_a)] : 8'h00;
          rsp_pend  = 0;
        end else lat--;
      end
      if (rsp_valid && rsp_ready) begin
        consumed = 1;
        outst    = 0;
        if (int'(rsp_data) != sigb(rd_k)) begin
          m_fail = 1; mf_addr = pt_addr(rd_k); mf_e = sigb(rd_k); mf_g = int'(rsp_data);
          m_busy = 0; m_done = 1;
        end else if (rd_k == nlines()) begin
          m_busy = 0; m_done = 1;
        end
        rd_k++;
      end

      req_ready = ($urandom_range(0, 3) != 0);
      if (req_valid && req_ready && m_busy) begin
        if (wr_k <= nlines()) begin
          chk(req_write == 1'b1, "R6", "write phase first", req_write, 1);
          chk(int'(req_addr) == pt_addr(wr_k), cur_inv ? "R4" : "R3", "write address",
              req_addr, pt_addr(wr_k));
          chk(int'(req_wdata) == sigb(wr_k), "R5", "signature", req_wdata, sigb(wr_k));
          mem[phys(int'(req_addr))] = req_wdata;
          if (wr_k == nlines()) begin gap = 0; gap_on = 1; end
          wr_k++;
        end else begin
          chk(req_write == 1'b0, "R6", "read phase after writes", req_write, 0);
          chk(int'(req_addr) == pt_addr(rd_k), cur_inv ? "R4" : "R3", "read address",
              req_addr, pt_addr(rd_k));
          rsp_pend = 1;
          rsp_a    = int'(req_addr);
          lat      = $urandom_range(0, 2);
          outst    = 1;
        end
      end

      if (start && !m_busy) begin
        m_busy = 1; m_done = 0; m_fail = 0;
        wr_k = 0; rd_k = 0; gap_on = 0;
      end
    end
  end

  task automatic run(input bit inv, input bit up, input int dly, input int s0,
                     input int s1, input bit mid_start, input bit want_fail);
    int t;
    @(posedge clk); #1;
    invert = inv; upper_scope = up; delay_cycles = DLY_W'(dly);
    stuck0 = s0; stuck1 = s1; mem.delete();
    cur_inv = inv; cur_up = up; cur_dly = dly;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    chk(fail == 1'b0, "R11", "fail cleared by start", fail, 0);
    chk(done == 1'b0, "R11", "done cleared by start", done, 0);
    if (mid_start) begin
      repeat (5) @(posedge clk); #1;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 5000) begin
      @(posedge clk); #1;
      t++;
    end
    chk(t < 5000, "R9", "run finishes", t, 0);
    chk(fail == want_fail, want_fail ? "R10" : "R9", "outcome", fail, want_fail);
    chk(fail == m_fail, "R10", "outcome vs model", fail, m_fail);
    if (m_fail) begin
      chk(int'(fail_addr) == mf_addr, "R10", "fail_addr", fail_addr, mf_addr);
      chk(int'(fail_exp) == mf_e, "R10", "fail_exp", fail_exp, mf_e);
      chk(int'(fail_got) == mf_g, "R10", "fail_got", fail_got, mf_g);
    end else begin
      chk(rd_k == nlines() + 1, "R6", "all points read", rd_k, nlines() + 1);
    end
    chk(wr_k == nlines() + 1, "R6", "all points written", wr_k, nlines() + 1);
    repeat (3) @(posedge clk); #1;
    chk(done == 1'b1 && busy == 1'b0, "R9", "result held", done, 1);
  endtask

  initial begin
    repeat (4) @(posedge clk); #1;
    rst_n = 1'b1;
    chk(busy == 0, "R1", "reset busy", busy, 0);
    chk(done == 0, "R1", "reset done", done, 0);
    chk(fail == 0, "R1", "reset fail", fail, 0);
    chk(req_valid == 0 && rsp_ready == 0, "R1", "reset streams", req_valid, 0);
    repeat (2) @(posedge clk);
    run(0, 0, 3,  0, 0, 0, 0);            // R3 page lines, clean
    run(0, 1, 0,  0, 0, 0, 0);            // R3 upper lines, zero delay
    run(1, 0, 7,  0, 0, 1, 0);            // R4 one-cold page, stray start (R2)
    run(1, 1, 1,  0, 0, 0, 0);            // R4 one-cold upper
    run(0, 0, 2,  32'h0008, 0, 0, 1);     // R10 bit3 stuck low aliases 8 onto 0
    run(0, 0, 2,  0, 0, 0, 0);            // R11 clean run after failure
    run(1, 1, 4,  0, 32'h1000, 0, 1);     // R10 bit12 stuck high, inverted upper
    run(0, 1, 5,  32'h0001, 0, 0, 0);     // R3 page fault invisible in upper scope
    run(0, 1, 2,  0, 32'h8000, 0, 1);     // R10 bit15 stuck high aliases base
    run(0, 0, 40, 0, 0, 0, 0);            // R7 long delay
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule